// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block decides, once per clock, whether the processor core must leave normal execution to serve an interrupt, and where it must go. Every source has three bits. The first is a request flag, which a hardware event sets and a software write clears. The second is an enable. The third is a priority select. A mode input chooses between two arrangements:

- **Two-level mode.** A high-priority handler can take over from a running low-priority handler.
- **Legacy mode.** There is one entry point. The same two global bits take on the roles of a master enable and a peripheral-group enable.

When an interrupt is accepted, the block does three things. It gives a one-cycle strobe, it presents the entry address, and it records which level is now active. While that level runs, its global enable is cleared so that the level cannot enter itself again. A return-from-interrupt input leaves the innermost active level and sets that level's global enable again. Pipeline redirection, the return-address stack and the sources themselves sit outside the block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is held, and until the first event after it, all flags are 0. Both global enables are 0, both nesting bits are 0, the strobe is 0 and the entry address is 0.
- R2: A 1 on `src_evt_i[i]` sets flag i at the next edge. A 1 on `flag_clr_i[i]` alone clears it. When both are 1 in the same cycle, the set wins.
- R3: In legacy mode (`prio_mode_i`=0) a source is pending when its flag and its enable are 1 and `gie_hi_o` is 1. A peripheral source (its bit set in PERIPH_MASK) also needs `gie_lo_o`=1. Every accepted request uses address 0x0008.
- R4: In two-level mode, a source with priority bit 1 is pending when its flag, its enable and `gie_hi_o` are all 1. It is accepted at address 0x0008. A source with priority bit 0 needs `gie_lo_o` instead. It is accepted at address 0x0018.
- R5: If high and low requests are both pending in one cycle, the high one is accepted.
- R6: The strobe rises on the edge that follows the cycle with a pending request. The strobe lasts one cycle. On that same edge, the accepted level's global enable drops to 0 and its nesting bit rises to 1. In legacy mode the accepted level is always the high one.
- R7: A high request is accepted while a low handler is active. In that case both nesting bits read 1.
- R8: A low request is not accepted while the high nesting bit is 1, even when `gie_lo_o` is 1.
- R9: On return-from-interrupt, the high level is cleared first if it is active, and its global enable is set to 1. Otherwise the low level is cleared and its global enable is set to 1. Nothing is accepted in a return cycle. A return with no level active changes nothing.
- R10: `ctl_wr_i` loads `ctl_wdata_i[1]` into `gie_hi_o` and `ctl_wdata_i[0]` into `gie_lo_o`. An accept or a return in the same cycle overrides this load.
- R11: A source whose enable is 0, or whose flag is 0, never causes an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt_i | input | NUM_SRC | Event pulses that set the request flags |
| flag_clr_i | input | NUM_SRC | Write-one-to-clear strobe for the flags |
| src_en_i | input | NUM_SRC | Per-source enable |
| src_pri_i | input | NUM_SRC | Per-source priority, 1 = high |
| prio_mode_i | input | 1 | 1 = two-level mode, 0 = legacy single address |
| ctl_wr_i | input | 1 | Load strobe for the global enables |
| ctl_wdata_i | input | 2 | Bit 1 = high/master enable, bit 0 = low/peripheral enable |
| reti_i | input | 1 | Return-from-interrupt |
| irq_take_o | output | 1 | One-cycle accept strobe |
| irq_vector_o | output | VEC_W | Entry address of the last accepted request |
| flag_o | output | NUM_SRC | Request flags |
| gie_hi_o | output | 1 | High/master global enable |
| gie_lo_o | output | 1 | Low/peripheral global enable |
| nest_hi_o | output | 1 | High-level handler active |
| nest_lo_o | output | 1 | Low-level handler active |

## Verification
Each pattern targets one property of the arbitration:

- **Directed sequences, legacy mode.** A flagged source sits behind a cleared enable, which shows that the individual enable gates the request. A peripheral source waits on the peripheral bit, which separates the legacy meaning of the two global bits from their two-level meaning.
- **Directed sequences, two-level mode.** A high and a low request arrive together, which exposes the winner. A low request waits inside a high handler, which exposes the hold-off rule. A high request arrives inside a low handler, which shows preemption and double nesting.
- **Returns.** A chain of returns shows the pop order. A return with no level active must change nothing.
- **Long random run.** Sparse events, clears, enable changes, mode flips, global writes and returns are compared every cycle against a bench model. This catches wrong overrides between a software write, an accept and a return in the same cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    GRANT_NONE = 2'd0,
    GRANT_HIGH = 2'd1,
    GRANT_LOW  = 2'd2
  } grant_e;

  typedef struct packed {
    logic gie_hi;
    logic gie_lo;
    logic nest_hi;
    logic nest_lo;
  } lvl_state_t;

  localparam lvl_state_t LVL_RESET = '{gie_hi: 1'b0, gie_lo: 1'b0, nest_hi: 1'b0, nest_lo: 1'b0};

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic flag_q;
    logic flag_d;
    logic flag_en;

    always_comb begin
      flag_en = evt_i[i] | clr_i[i];
      flag_d  = evt_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (flag_en) begin
        flag_q <= flag_d;
      end
    end

    assign flag_o[i] = flag_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> flag_o[i]); // R2
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !evt_i[i]) |=> !flag_o[i]); // R2
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !evt_i[i]) |=> $stable(flag_o[i])); // R2
  end

endmodule

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int               NUM_SRC     = 8,
  parameter logic [NUM_SRC-1:0] PERIPH_MASK = '0
) (
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] pri_i,
  input  logic               prio_mode_i,
  input  logic               gie_hi_i,
  input  logic               gie_lo_i,
  input  logic               nest_hi_i,
  output logic               req_hi_o,
  output logic               req_lo_o
);

  logic [NUM_SRC-1:0] armed;
  logic [NUM_SRC-1:0] want_hi;
  logic [NUM_SRC-1:0] want_lo;
  logic [NUM_SRC-1:0] legacy_ok;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign armed[i] = flag_i[i] & en_i[i];

    if (PERIPH_MASK[i]) begin : g_periph
      assign legacy_ok[i] = gie_lo_i;
    end else begin : g_core
      assign legacy_ok[i] = 1'b1;
    end

    assign want_hi[i] = prio_mode_i ? (armed[i] & pri_i[i]) : (armed[i] & legacy_ok[i]);
    assign want_lo[i] = prio_mode_i & armed[i] & ~pri_i[i];
  end

  always_comb begin
    req_hi_o = gie_hi_i & (|want_hi);
    req_lo_o = gie_lo_i & ~nest_hi_i & (|want_lo);
  end

endmodule

// File: rtl/irq_level_seq.sv
module irq_level_seq
  import irq_ctrl_pkg::*;
#(
  parameter int               VEC_W  = 16,
  parameter logic [VEC_W-1:0] HI_VEC = 16'h0008,
  parameter logic [VEC_W-1:0] LO_VEC = 16'h0018
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_hi_i,
  input  logic             req_lo_i,
  input  logic             reti_i,
  input  logic             ctl_wr_i,
  input  logic [1:0]       ctl_wdata_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             gie_hi_o,
  output logic             gie_lo_o,
  output logic             nest_hi_o,
  output logic             nest_lo_o
);

  lvl_state_t       st_q;
  lvl_state_t       st_d;
  grant_e           grant;
  logic             take_q;
  logic             take_d;
  logic [VEC_W-1:0] vec_q;
  logic [VEC_W-1:0] vec_d;
  logic             vec_en;

  always_comb begin
    st_d  = st_q;
    grant = GRANT_NONE;

    if (ctl_wr_i) begin
      st_d.gie_hi = ctl_wdata_i[1];
      st_d.gie_lo = ctl_wdata_i[0];
    end

    if (reti_i) begin
      if (st_q.nest_hi) begin
        st_d.nest_hi = 1'b0;
        st_d.gie_hi  = 1'b1;
      end else if (st_q.nest_lo) begin
        st_d.nest_lo = 1'b0;
        st_d.gie_lo  = 1'b1;
      end
    end else if (req_hi_i) begin
      grant = GRANT_HIGH;
    end else if (req_lo_i) begin
      grant = GRANT_LOW;
    end

    case (grant)
      GRANT_HIGH: begin
        st_d.gie_hi  = 1'b0;
        st_d.nest_hi = 1'b1;
      end
      GRANT_LOW: begin
        st_d.gie_lo  = 1'b0;
        st_d.nest_lo = 1'b1;
      end
      default: ;
    endcase

    take_d = (grant != GRANT_NONE);
    vec_en = take_d;
    vec_d  = (grant == GRANT_LOW) ? LO_VEC : HI_VEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LVL_RESET;
      take_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      take_q <= take_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (vec_en) begin
      vec_q <= vec_d;
    end
  end

  assign take_o    = take_q;
  assign vector_o  = vec_q;
  assign gie_hi_o  = st_q.gie_hi;
  assign gie_lo_o  = st_q.gie_lo;
  assign nest_hi_o = st_q.nest_hi;
  assign nest_lo_o = st_q.nest_lo;

  AST_HI_TAKE_MASKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vector_o == HI_VEC) |-> (!gie_hi_o && nest_hi_o)); // R6
  AST_LO_TAKE_MASKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vector_o == LO_VEC) |-> (!gie_lo_o && nest_lo_o)); // R6
  AST_NOTHING_AFTER_HI_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vector_o == HI_VEC) |=> !take_o); // R8
  AST_LO_NOT_INSIDE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vector_o == LO_VEC) |-> !$past(nest_hi_o)); // R8
  AST_RETI_POPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && nest_hi_o) |=> (!nest_hi_o && gie_hi_o && !take_o)); // R9
  AST_RETI_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !nest_hi_o && !nest_lo_o && !ctl_wr_i) |=>
      ($stable({gie_hi_o, gie_lo_o}) && !take_o && !nest_hi_o && !nest_lo_o)); // R9

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int                 NUM_SRC     = 8,
  parameter logic [NUM_SRC-1:0] PERIPH_MASK = 8'hF0,
  parameter int                 VEC_W       = 16,
  parameter logic [VEC_W-1:0]   HI_VEC      = 16'h0008,
  parameter logic [VEC_W-1:0]   LO_VEC      = 16'h0018
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic [NUM_SRC-1:0] flag_clr_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic [NUM_SRC-1:0] src_pri_i,
  input  logic               prio_mode_i,
  input  logic               ctl_wr_i,
  input  logic [1:0]         ctl_wdata_i,
  input  logic               reti_i,
  output logic               irq_take_o,
  output logic [VEC_W-1:0]   irq_vector_o,
  output logic [NUM_SRC-1:0] flag_o,
  output logic               gie_hi_o,
  output logic               gie_lo_o,
  output logic               nest_hi_o,
  output logic               nest_lo_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   req_hi;
  logic                   req_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .evt_i  (src_evt_i),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  irq_qualify #(.NUM_SRC(NUM_SRC), .PERIPH_MASK(PERIPH_MASK)) u_qual (
    .flag_i      (flag_o),
    .en_i        (src_en_i),
    .pri_i       (src_pri_i),
    .prio_mode_i (prio_mode_i),
    .gie_hi_i    (gie_hi_o),
    .gie_lo_i    (gie_lo_o),
    .nest_hi_i   (nest_hi_o),
    .req_hi_o    (req_hi),
    .req_lo_o    (req_lo)
  );

  irq_level_seq #(.VEC_W(VEC_W), .HI_VEC(HI_VEC), .LO_VEC(LO_VEC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_hi_i    (req_hi),
    .req_lo_i    (req_lo),
    .reti_i      (reti_i),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_wdata_i (ctl_wdata_i),
    .take_o      (irq_take_o),
    .vector_o    (irq_vector_o),
    .gie_hi_o    (gie_hi_o),
    .gie_lo_o    (gie_lo_o),
    .nest_hi_o   (nest_hi_o),
    .nest_lo_o   (nest_lo_o)
  );

  AST_LO_VEC_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_take_o && irq_vector_o == LO_VEC) |-> $past(prio_mode_i)); // R4
  AST_NO_TAKE_WHEN_UNARMED: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((flag_o & src_en_i) == '0 && !reti_i) |=> !irq_take_o); // R11

endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;

  localparam int          N      = 8;
  localparam logic [N-1:0] PMASK = 8'hF0;
  localparam logic [15:0]  HV    = 16'h0008;
  localparam logic [15:0]  LV    = 16'h0018;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] evt, clr, en, pri;
  logic mode, cwr, reti;
  logic [1:0] cdat;
  logic take;
  logic [15:0] vec;
  logic [N-1:0] flag;
  logic gh, gl, nh, nl;

  int nchk = 0;
  int nerr = 0;

  logic [N-1:0] m_flag;
  logic m_gh, m_gl, m_nh, m_nl, m_take;
  logic [15:0] m_vec;

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(N), .PERIPH_MASK(PMASK)) uut (
    .clk(clk), .rst_n(rst_n), .src_evt_i(evt), .flag_clr_i(clr), .src_en_i(en),
    .src_pri_i(pri), .prio_mode_i(mode), .ctl_wr_i(cwr), .ctl_wdata_i(cdat),
    .reti_i(reti), .irq_take_o(take), .irq_vector_o(vec), .flag_o(flag),
    .gie_hi_o(gh), .gie_lo_o(gl), .nest_hi_o(nh), .nest_lo_o(nl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] mdl_req();
    logic [N-1:0] armed, whi, wlo;
    armed = m_flag & en;
    if (mode) begin
      whi = armed & pri;
      wlo = armed & ~pri;
    end else begin
      whi = armed & (~PMASK | {N{m_gl}});
      wlo = '0;
    end
    return {m_gh & (|whi), m_gl & ~m_nh & (|wlo)};
  endfunction

  task automatic mdl_step();
    logic [1:0] r;
    r = mdl_req();
    m_flag = (m_flag & ~clr) | evt;
    if (cwr) begin
      m_gh = cdat[1];
      m_gl = cdat[0];
    end
    m_take = 1'b0;
    if (reti) begin
      if (m_nh) begin m_nh = 1'b0; m_gh = 1'b1; end
      else if (m_nl) begin m_nl = 1'b0; m_gl = 1'b1; end
    end else if (r[1]) begin
      m_take = 1'b1; m_vec = HV; m_gh = 1'b0; m_nh = 1'b1;
    end else if (r[0]) begin
      m_take = 1'b1; m_vec = LV; m_gl = 1'b0; m_nl = 1'b1;
    end
  endtask

  task automatic tick();
    mdl_step();
    @(posedge clk);
    @(negedge clk);
    chk("R6 strobe", take, m_take);
    chk("R4 address", vec, m_vec);
    chk("R2 flags", flag, m_flag);
    chk("R10 enables", {gh, gl}, {m_gh, m_gl});
    chk("R7 nesting", {nh, nl}, {m_nh, m_nl});
    evt = '0; clr = '0; cwr = 1'b0; reti = 1'b0;
  endtask

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; evt = '0; clr = '0; en = '0; pri = '0;
    mode = 1'b0; cwr = 1'b0; cdat = 2'b00; reti = 1'b0;
    m_flag = '0; m_gh = 0; m_gl = 0; m_nh = 0; m_nl = 0; m_take = 0; m_vec = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 strobe", take, 0);
    chk("R1 address", vec, 0);
    chk("R1 flags", flag, 0);
    chk("R1 enables", {gh, gl}, 0);
    chk("R1 nesting", {nh, nl}, 0);

    // R10 software load of global bits
    cwr = 1'b1; cdat = 2'b10; tick();
    chk("R10 hi", gh, 1); chk("R10 lo", gl, 0);

    // R11 flagged but disabled source
    en = '0; evt = 8'h01; tick(); tick(); tick();
    chk("R11 disabled source", take, 0);

    // R3 peripheral source waits on peripheral enable in legacy mode
    en = 8'h10; evt = 8'h10; tick(); tick();
    chk("R3 peripheral gated", take, 0);

    // R3 legacy accept at single address
    en = 8'h11; tick();
    chk("R3 take", take, 1); chk("R3 address", vec, HV);
    chk("R6 hi cleared", gh, 0); chk("R6 nest", nh, 1);
    tick();
    chk("R6 single pulse", take, 0);
    clr = 8'h11; tick();
    reti = 1'b1; tick();
    chk("R9 pop hi", {nh, gh}, 2'b01);

    // R5 simultaneous high and low in two-level mode
    mode = 1'b1; cwr = 1'b1; cdat = 2'b11; en = 8'h03; pri = 8'h01; tick();
    evt = 8'h03; tick();
    tick();
    chk("R5 take", take, 1); chk("R5 high wins", vec, HV);

    // R8 low held inside high handler
    tick(); tick();
    chk("R8 low held", take, 0); chk("R8 lo enable", gl, 1);
    clr = 8'h01; tick();
    reti = 1'b1; tick();
    chk("R9 no take on return", take, 0);
    tick();
    chk("R4 low take", take, 1); chk("R4 low address", vec, LV);
    chk("R6 lo cleared", {gl, nl}, 2'b01);

    // R7 high preempts low
    evt = 8'h01; tick();
    tick();
    chk("R7 take", take, 1); chk("R7 address", vec, HV);
    chk("R7 both nested", {nh, nl}, 2'b11);

    // R9 return chain and idle return
    clr = 8'h03; tick();
    reti = 1'b1; tick();
    chk("R9 first pop", {nh, nl, gh}, 3'b011);
    reti = 1'b1; tick();
    chk("R9 second pop", {nl, gl}, 2'b01);
    reti = 1'b1; tick();
    chk("R9 idle return", {gh, gl, nh, nl, take}, 5'b11000);

    // R2 set wins over clear, then clear alone
    evt = 8'h80; clr = 8'h80; tick();
    chk("R2 set wins", flag[7], 1);
    clr = 8'h80; tick();
    chk("R2 cleared", flag[7], 0);

    // random phase against the model
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++) begin
        evt[i] = ($urandom % 12) == 0;
        clr[i] = ($urandom % 6) == 0;
      end
      if (($urandom % 40) == 0) begin en = N'($urandom); pri = N'($urandom); end
      if (($urandom % 300) == 0) mode = ~mode;
      if (($urandom % 25) == 0) begin cwr = 1'b1; cdat = 2'($urandom); end
      reti = (m_nh | m_nl) ? (($urandom % 5) == 0) : (($urandom % 40) == 0);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule